// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block owns the program counter of a signal-processing core and runs hardware loops without spending any branch instructions. When the decoder sees a loop-setup instruction at address P, it presents the last address of the loop body and either a pass count or a request to end on a condition. The sequencer records P+1 as the loop head on a small frame stack. From then on, each time the PC lands on the recorded tail address, the PC-update logic picks between jumping back to the head and falling through. The choice depends on the remaining pass count or on the condition input. Loops nest up to the stack depth. When a loop finishes, its frame is popped and the enclosing loop takes over the tail check.

A second mode repeats the single instruction that follows a repeat-setup instruction for a programmed number of executions. During those executions the PC is held and no refetch is needed, and an output tells the interrupt controller to hold off requests. A stall input freezes the PC and every loop counter. The block does not fetch or decode instructions. It takes decoded setup strobes and returns the PC and the next PC.

Top module: `zloop_seq`

## Requirements
- R1: While reset is asserted at a clock edge, the PC becomes RESET_PC (0 by default), the overflow flag clears and the interrupt-hold output goes low.
- R2: A loop setup accepted while the PC is P stores P+1 as the loop head, and the next PC is P+1.
- R3: In count mode, with a count N from 1 to 2^ITER_W-1, the tail address is reached exactly N times. After the first N-1 visits the PC jumps back to the head, and after the Nth it goes to tail+1. A body of L instructions therefore takes N*L cycles.
- R4: A count of 0 in count mode gives 2^ITER_W passes.
- R5: In condition mode, at the tail, a low condition input sends the PC back to the head and a high one sends it to tail+1. The count field has no effect in this mode.
- R6: Up to DEPTH (4) loops nest. When an inner loop exits, its frame is popped and the enclosing loop's tail check resumes. An inner loop set up again on each outer pass runs its full count each time.
- R7: A loop setup that arrives while DEPTH frames are held is dropped. The overflow flag sets and stays set until reset, and the PC keeps advancing by one, checked against the frames that remain.
- R8: A repeat setup at P with count N executes the instruction at P+1 N times (a count of 0 means 256 times) with the PC held at P+1, and then goes on to P+2. Setup strobes are ignored while a repeat is active.
- R9: The interrupt-hold output is high in exactly the N cycles in which the repeated instruction executes, and low otherwise.
- R10: While the stall input is high, the PC, the loop counts and the repeat count do not change, and the next-PC output equals the PC.
- R11: The next-PC output is the value the PC takes at the next clock edge.
- R12: A loop whose body is a single instruction (tail = P+1, head equal to tail) runs its programmed passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze PC and all loop state for this cycle |
| do_i | input | 1 | Loop-setup instruction at the current PC |
| do_tail_i | input | PC_W | Last address of the loop body |
| do_iters_i | input | ITER_W | Pass count (0 = 2^ITER_W), count mode only |
| do_on_cond_i | input | 1 | 1: the loop ends on the condition; 0: the loop ends on the count |
| rpt_i | input | 1 | Repeat-setup instruction at the current PC |
| rpt_cnt_i | input | RPT_W | Number of executions (0 = 2^RPT_W) |
| cond_i | input | 1 | Termination condition, sampled at the tail |
| pc_o | output | PC_W | Current program counter |
| next_pc_o | output | PC_W | Program counter after the next clock edge |
| irq_hold_o | output | 1 | Interrupts must be held off (repeat active) |
| ovf_o | output | 1 | Sticky loop-stack overflow flag |

## Verification
Count-mode loops are swept over body lengths 1 to 3 and counts 1 to 5. Counting visits to the tail and the total cycles tells an off-by-one exit apart from a wrong jump target, and the one-instruction body shows whether head-equals-tail is handled. A count of 0 checks the maximum-pass rule against a 0-or-1-pass misreading. Condition-ended loops carry a count field of 1, so a design that wrongly obeys the count ends too early. A grid of nested counts shows whether the outer frame resumes correctly after a pop. Further runs cover five stacked setups for overflow, repeats of 1 to 4 and 256 executions with a setup strobe placed on the repeated instruction, and a stall in the middle of a loop that must leave the pass count unchanged.

// File: rtl/zls_pkg.sv
package zls_pkg;

    localparam int unsigned PC_W   = 16;
    localparam int unsigned ITER_W = 16;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [ITER_W-1:0] iter_t;

    // One hardware-loop frame held on the stack.
    typedef struct packed {
        pc_t   head_pc;   // first body address
        pc_t   tail_pc;   // last body address
        iter_t iters;     // passes still to run, 0 stands for 2^ITER_W
        logic  on_cond;   // loop ends on the condition input
    } loop_frame_t;

    // What the PC-update logic chose in a cycle.
    typedef enum logic [2:0] {
        ACT_SEQ    = 3'd0,
        ACT_HOLD   = 3'd1,
        ACT_ENTER  = 3'd2,
        ACT_ARM    = 3'd3,
        ACT_BACK   = 3'd4,
        ACT_EXIT   = 3'd5,
        ACT_FREEZE = 3'd6
    } seq_act_t;

    function automatic pc_t pc_inc(input pc_t p);
        return p + pc_t'(1);
    endfunction

    function automatic logic last_pass(input iter_t n);
        return n == iter_t'(1);
    endfunction

    function automatic iter_t iter_dec(input iter_t n);
        return n - iter_t'(1);
    endfunction

endpackage

// File: rtl/zls_stack.sv
module zls_stack
    import zls_pkg::*;
#(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  loop_frame_t       push_frame,
    input  logic              pop_en,
    input  logic              dec_en,
    output logic              top_valid,
    output loop_frame_t       top_frame,
    output logic [FILL_W-1:0] fill,
    output logic              overflow
);

    loop_frame_t slots [DEPTH];
    logic        full;

    assign full      = (fill == FILL_W'(DEPTH));
    assign top_valid = (fill != '0);

    // Frame storage: a push lands above the current top, a decrement hits the top.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_en && !full && fill == FILL_W'(i)) begin
                    slots[i] <= push_frame;
                end else if (dec_en && fill == FILL_W'(i + 1)) begin
                    slots[i].iters <= iter_dec(slots[i].iters);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= '0;
        end else if (push_en && !full) begin
            fill <= fill + FILL_W'(1);
        end else if (pop_en && top_valid) begin
            fill <= fill - FILL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (push_en && full) begin
            overflow <= 1'b1;
        end
    end

    // Top-of-stack selection, one comparator per slot.
    logic [DEPTH-1:0] sel;
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        assign sel[g] = (fill == FILL_W'(g + 1));
    end

    always_comb begin
        top_frame = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                top_frame = slots[i];
            end
        end
    end

endmodule

// File: rtl/zls_rpt.sv
module zls_rpt #(
    parameter int unsigned RPT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_en,
    input  logic [RPT_W-1:0] arm_cnt,
    input  logic             step_en,
    output logic             active,
    output logic             hold
);

    logic [RPT_W-1:0] left_q;

    // left_q counts the executions still to come, the current one included.
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            left_q <= '0;
        end else if (arm_en) begin
            active <= 1'b1;
            left_q <= arm_cnt;
        end else if (step_en && active) begin
            if (left_q == RPT_W'(1)) begin
                active <= 1'b0;
            end else begin
                left_q <= left_q - RPT_W'(1);
            end
        end
    end

    assign hold = active && (left_q != RPT_W'(1));

endmodule

// File: rtl/zls_next.sv
module zls_next
    import zls_pkg::*;
(
    input  logic        stall,
    input  logic        rpt_active,
    input  logic        rpt_hold,
    input  logic        do_req,
    input  logic        rpt_req,
    input  logic        cond,
    input  logic        top_valid,
    input  loop_frame_t top,
    input  pc_t         pc,
    output seq_act_t    act,
    output pc_t         next_pc
);

    logic at_tail;

    assign at_tail = top_valid && (pc == top.tail_pc);

    // Priority: stall, repeat hold, setup, tail check, straight line.
    always_comb begin
        if (stall) begin
            act = ACT_FREEZE;
        end else if (rpt_hold) begin
            act = ACT_HOLD;
        end else if (!rpt_active && do_req) begin
            act = ACT_ENTER;
        end else if (!rpt_active && rpt_req) begin
            act = ACT_ARM;
        end else if (at_tail) begin
            if (top.on_cond) begin
                act = cond ? ACT_EXIT : ACT_BACK;
            end else begin
                act = last_pass(top.iters) ? ACT_EXIT : ACT_BACK;
            end
        end else begin
            act = ACT_SEQ;
        end
    end

    always_comb begin
        unique case (act)
            ACT_FREEZE, ACT_HOLD: next_pc = pc;
            ACT_BACK:             next_pc = top.head_pc;
            default:              next_pc = pc_inc(pc);
        endcase
    end

endmodule

// File: rtl/zloop_seq.sv
module zloop_seq
    import zls_pkg::*;
#(
    parameter int unsigned    DEPTH    = 4,
    parameter int unsigned    RPT_W    = 8,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall_i,
    input  logic              do_i,
    input  logic [PC_W-1:0]   do_tail_i,
    input  logic [ITER_W-1:0] do_iters_i,
    input  logic              do_on_cond_i,
    input  logic              rpt_i,
    input  logic [RPT_W-1:0]  rpt_cnt_i,
    input  logic              cond_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   next_pc_o,
    output logic              irq_hold_o,
    output logic              ovf_o
);

    localparam int unsigned FILL_W = $clog2(DEPTH + 1);

    pc_t               pc_q;
    pc_t               pc_d;
    seq_act_t          act;
    loop_frame_t       new_frame;
    loop_frame_t       top_frame;
    logic              top_valid;
    logic [FILL_W-1:0] stack_fill;
    logic              rpt_active;
    logic              rpt_hold;

    always_comb begin
        new_frame.head_pc = pc_inc(pc_q);
        new_frame.tail_pc = do_tail_i;
        new_frame.iters   = do_iters_i;
        new_frame.on_cond = do_on_cond_i;
    end

    zls_next u_next (
        .stall      (stall_i),
        .rpt_active (rpt_active),
        .rpt_hold   (rpt_hold),
        .do_req     (do_i),
        .rpt_req    (rpt_i),
        .cond       (cond_i),
        .top_valid  (top_valid),
        .top        (top_frame),
        .pc         (pc_q),
        .act        (act),
        .next_pc    (pc_d)
    );

    zls_stack #(
        .DEPTH  (DEPTH),
        .FILL_W (FILL_W)
    ) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_en    (act == ACT_ENTER),
        .push_frame (new_frame),
        .pop_en     (act == ACT_EXIT),
        .dec_en     ((act == ACT_BACK) && !top_frame.on_cond),
        .top_valid  (top_valid),
        .top_frame  (top_frame),
        .fill       (stack_fill),
        .overflow   (ovf_o)
    );

    zls_rpt #(
        .RPT_W (RPT_W)
    ) u_rpt (
        .clk     (clk),
        .rst     (rst),
        .arm_en  (act == ACT_ARM),
        .arm_cnt (rpt_cnt_i),
        .step_en (!stall_i),
        .active  (rpt_active),
        .hold    (rpt_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc_o       = pc_q;
    assign next_pc_o  = pc_d;
    assign irq_hold_o = rpt_active;

endmodule

// File: rtl/zls_chk.sv
module zls_chk
    import zls_pkg::*;
#(
    parameter int unsigned     DEPTH    = 4,
    parameter int unsigned     FILL_W   = 3,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              stall_i,
    input logic              do_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PC_W-1:0]   next_pc_o,
    input logic              irq_hold_o,
    input logic              ovf_o,
    input logic [FILL_W-1:0] fill_i
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_o == RESET_PC) && !ovf_o && !irq_hold_o);

    assert_enter_step_R2: assert property (@(posedge clk) disable iff (rst)
        (do_i && !stall_i && !irq_hold_o) |=> (pc_o == pc_inc($past(pc_o))));

    assert_depth_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill_i <= FILL_W'(DEPTH));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    assert_rpt_holds_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_hold_o && $past(irq_hold_o)) |-> (pc_o == $past(pc_o)));

    assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> (pc_o == $past(pc_o)));

    assert_next_follows_R11: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> (pc_o == $past(next_pc_o)));

endmodule

bind zloop_seq zls_chk #(
    .DEPTH    (DEPTH),
    .FILL_W   (FILL_W),
    .RESET_PC (RESET_PC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stall_i    (stall_i),
    .do_i       (do_i),
    .pc_o       (pc_o),
    .next_pc_o  (next_pc_o),
    .irq_hold_o (irq_hold_o),
    .ovf_o      (ovf_o),
    .fill_i     (stack_fill)
);

// File: tb/sim_zloop_seq.sv
`timescale 1ns/1ps
module sim_zloop_seq;

    localparam int unsigned WD_MAX = 195000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall_i = 1'b0;
    logic        do_i;
    logic [15:0] do_tail_i;
    logic [15:0] do_iters_i;
    logic        do_on_cond_i;
    logic        rpt_i;
    logic [7:0]  rpt_cnt_i;
    logic        cond_i = 1'b0;
    logic [15:0] pc_o;
    logic [15:0] next_pc_o;
    logic        irq_hold_o;
    logic        ovf_o;

    always #2 clk = ~clk;

    zloop_seq u0 (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall_i),
        .do_i         (do_i),
        .do_tail_i    (do_tail_i),
        .do_iters_i   (do_iters_i),
        .do_on_cond_i (do_on_cond_i),
        .rpt_i        (rpt_i),
        .rpt_cnt_i    (rpt_cnt_i),
        .cond_i       (cond_i),
        .pc_o         (pc_o),
        .next_pc_o    (next_pc_o),
        .irq_hold_o   (irq_hold_o),
        .ovf_o        (ovf_o)
    );

    // Program image: setup instructions keyed on address.
    int unsigned n_do = 0;
    logic [15:0] p_at   [5];
    logic [15:0] p_tail [5];
    logic [15:0] p_cnt  [5];
    logic        p_cond [5];
    logic        rpt_on = 1'b0;
    logic [15:0] rpt_at = '0;
    logic [7:0]  rpt_n  = '0;

    always_comb begin
        do_i = 1'b0; do_tail_i = '0; do_iters_i = '0; do_on_cond_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (k < int'(n_do) && pc_o == p_at[k]) begin
                do_i = 1'b1; do_tail_i = p_tail[k];
                do_iters_i = p_cnt[k]; do_on_cond_i = p_cond[k];
            end
        end
        rpt_i     = rpt_on && (pc_o == rpt_at);
        rpt_cnt_i = rpt_n;
    end

    int unsigned n_chk = 0, n_fail = 0, wd = 0, nxt_bad = 0;
    int unsigned cyc, va, vb, irq_n, irq_bad, stall_seen, stall_bad;
    logic        cond_on = 1'b0;
    int unsigned cond_k = 0, st_visit = 0, st_len = 0;
    logic        timed_out = 1'b0;

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        n_do = 0; rpt_on = 1'b0; cond_on = 1'b0; st_visit = 0; st_len = 0;
        for (int k = 0; k < 5; k++) begin
            p_at[k] = 16'hFFFF; p_tail[k] = '0; p_cnt[k] = '0; p_cond[k] = 1'b0;
        end
    endtask

    task automatic add_do(input logic [15:0] at, input logic [15:0] tail,
                          input logic [15:0] cnt, input logic oc);
        p_at[n_do] = at; p_tail[n_do] = tail; p_cnt[n_do] = cnt; p_cond[n_do] = oc;
        n_do++;
    endtask

    task automatic do_reset();
        rst = 1'b1; stall_i = 1'b0; cond_i = 1'b0;
        repeat (2) @(negedge clk);
        wd += 2;
        rst = 1'b0;
    endtask

    // Runs until pc_o reaches target; counts visits to a and b.
    task automatic run(input logic [15:0] target, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] irq_pc);
        logic [15:0] p, prev_next, prev_pc;
        logic        prev_st, have_prev, st_done;
        int unsigned st_left;
        cyc = 0; va = 0; vb = 0; irq_n = 0; irq_bad = 0; stall_seen = 0; stall_bad = 0;
        have_prev = 1'b0; prev_st = 1'b0; prev_next = '0; prev_pc = '0;
        st_left = 0; st_done = 1'b0;
        forever begin
            @(negedge clk);
            wd++;
            p = pc_o;
            if (have_prev && !prev_st && p != prev_next) nxt_bad++;
            if (have_prev && prev_st && p != prev_pc) stall_bad++;
            if (p == target) break;
            if (wd > WD_MAX) begin timed_out = 1'b1; break; end
            cond_i = 1'b0;
            if (st_left > 0) begin
                stall_i = 1'b1; st_left--; stall_seen++;
            end else begin
                stall_i = 1'b0;
                if (p == a && st_visit != 0 && !st_done && va + 1 == st_visit) begin
                    stall_i = 1'b1; st_left = st_len - 1; st_done = 1'b1; stall_seen++;
                end else begin
                    if (p >= 16'd2) cyc++;
                    if (p == a) begin
                        va++;
                        if (cond_on) cond_i = (va == cond_k);
                    end
                    if (p == b) vb++;
                end
            end
            if (irq_hold_o) begin
                irq_n++;
                if (p != irq_pc) irq_bad++;
            end
            #1;
            if (stall_i && next_pc_o != p) stall_bad++;
            prev_next = next_pc_o; prev_st = stall_i; prev_pc = p; have_prev = 1'b1;
        end
        stall_i = 1'b0; cond_i = 1'b0;
        if (timed_out) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: pc %0d never reached %0d", pc_o, target);
        end
    endtask

    initial begin
        clear_prog();
        // R1: reset state
        do_reset();
        rst = 1'b1;
        @(negedge clk);
        check(pc_o == 16'd0, "R1", "pc after reset", pc_o, 0);
        check(!ovf_o, "R1", "ovf after reset", ovf_o, 0);
        check(!irq_hold_o, "R1", "irq hold after reset", irq_hold_o, 0);

        // R2 R3 R12: count loops, body length L, count N
        for (int L = 1; L <= 3; L++) begin
            for (int N = 1; N <= 5; N++) begin
                clear_prog();
                add_do(16'd2, 16'(2 + L), 16'(N), 1'b0);
                do_reset();
                run(16'(3 + L), 16'(2 + L), 16'd3, 16'hFFFF);
                check(va == N, L == 1 ? "R12" : "R3", "tail visits", va, N);
                check(cyc == 1 + N * L, "R3", "loop cycles", cyc, 1 + N * L);
                check(vb == N, "R2", "head visits", vb, N);
            end
        end

        // R4: count 0 means 2^16 passes
        clear_prog();
        add_do(16'd2, 16'd3, 16'd0, 1'b0);
        do_reset();
        run(16'd4, 16'd3, 16'd3, 16'hFFFF);
        check(va == 65536, "R4", "passes for count 0", va, 65536);

        // R5: condition-ended loop, count field 1 must be ignored
        for (int K = 1; K <= 4; K++) begin
            clear_prog();
            add_do(16'd2, 16'd4, 16'd1, 1'b1);
            cond_on = 1'b1; cond_k = K;
            do_reset();
            run(16'd5, 16'd4, 16'd3, 16'hFFFF);
            check(va == K, "R5", "cond passes", va, K);
            check(cyc == 1 + 2 * K, "R5", "cond cycles", cyc, 1 + 2 * K);
        end

        // R6: nested loops, outer 2..8, inner 4..6
        for (int A = 1; A <= 3; A++) begin
            for (int B = 1; B <= 3; B++) begin
                clear_prog();
                add_do(16'd2, 16'd8, 16'(A), 1'b0);
                add_do(16'd4, 16'd6, 16'(B), 1'b0);
                do_reset();
                run(16'd9, 16'd8, 16'd6, 16'hFFFF);
                check(va == A, "R6", "outer passes", va, A);
                check(vb == A * B, "R6", "inner passes", vb, A * B);
                check(cyc == 1 + A * (4 + 2 * B), "R6", "nest cycles", cyc, 1 + A * (4 + 2 * B));
            end
        end

        // R7: five setups on a four-deep stack
        clear_prog();
        for (int k = 0; k < 5; k++) add_do(16'(2 + k), 16'(20 - k), 16'd1, 1'b0);
        do_reset();
        run(16'd6, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check(!ovf_o, "R7", "ovf with four frames", ovf_o, 0);
        run(16'd21, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        check(ovf_o, "R7", "ovf after fifth setup", ovf_o, 1);
        check(cyc == 14, "R7", "straight-line cycles after overflow", cyc, 14);

        // R8 R9: single-instruction repeat
        for (int N = 0; N <= 4; N++) begin
            int exp_n;
            exp_n = (N == 0) ? 256 : N;
            clear_prog();
            rpt_on = 1'b1; rpt_at = 16'd2; rpt_n = 8'(N);
            do_reset();
            run(16'd5, 16'd3, 16'd4, 16'd3);
            check(va == exp_n, "R8", "repeat executions", va, exp_n);
            check(cyc == 2 + exp_n, "R8", "repeat cycles", cyc, 2 + exp_n);
            check(irq_n == exp_n, "R9", "irq hold cycles", irq_n, exp_n);
            check(irq_bad == 0, "R9", "irq hold outside repeat", irq_bad, 0);
        end

        // R8: a setup strobe on the repeated instruction is ignored
        clear_prog();
        rpt_on = 1'b1; rpt_at = 16'd2; rpt_n = 8'd3;
        add_do(16'd3, 16'd5, 16'd2, 1'b0);
        do_reset();
        run(16'd6, 16'd5, 16'd3, 16'd3);
        check(va == 1, "R8", "setup during repeat ignored", va, 1);

        // R10: stall on the second tail visit for three cycles
        clear_prog();
        add_do(16'd2, 16'd4, 16'd3, 1'b0);
        st_visit = 2; st_len = 3;
        do_reset();
        run(16'd5, 16'd4, 16'd3, 16'hFFFF);
        check(va == 3, "R10", "passes with stall", va, 3);
        check(cyc == 7, "R10", "unstalled cycles", cyc, 7);
        check(stall_seen == 3, "R10", "stalled cycles", stall_seen, 3);
        check(stall_bad == 0, "R10", "pc moved during stall", stall_bad, 0);

        // R11: next-PC prediction over every run above
        check(nxt_bad == 0, "R11", "next pc mismatches", nxt_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule